// File: doc/BRIEF.md
# Destination address hash filter

This block decides whether a received frame is addressed to this station. The 48-bit destination address streams in during reception, either a byte per clock or a bit per clock, chosen by a parameter. While it arrives, the block keeps the address bits and runs a reflected CRC-32 over them. Once the last address beat has been taken, the block accepts the frame in three cases. The first is an exact match with the programmed station address. The second is the all-ones broadcast address. The third is a set bit in a 64-bit hash table, selected by six bits of the CRC.

The receive path pulses `frameStart` at the start of every frame and then presents address beats on `beatData`, qualified by `beatValid`. One cycle after the final beat, `decisionValid` pulses. The `accept` flag and the `hashIndex` value keep the result of the completed frame until the next `frameStart`. Software programs the station address and the hash table through static inputs. The low half of the second station-address word holds a fixed frame type value for flow control and never enters the filter, so only bytes 4 and 5 are wired in.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `decisionValid` is 0 and `hashIndex` is 6'h3F, because the CRC register holds all ones.
- R2: The CRC starts from 32'hFFFFFFFF and takes the address bytes in order, byte 0 first and each byte least significant bit first. For each bit, the register shifts right by one and is XORed with 32'hEDB88320 when the incoming bit differs from the register's bit 0. `hashIndex` equals bits 31:26 of the final CRC.
- R3: The frame is accepted when the address equals the station address. `stationHi[31:24]` holds byte 0, `stationHi[7:0]` holds byte 3, `stationTail[15:8]` holds byte 4 and `stationTail[7:0]` holds byte 5. Byte 0 is the first byte received.
- R4: The frame is accepted when all 48 address bits are one.
- R5: When `hashIndex` is 32 or more, bit `hashIndex-32` of `hashUpper` decides acceptance. Otherwise bit `hashIndex` of `hashLower` decides it. A bit set only in the other word has no effect.
- R6: The frame is rejected when it is not broadcast, the address differs from the station address, and the selected hash bit is 0.
- R7: `decisionValid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte beat. Idle cycles between beats only delay it.
- R8: `frameStart` reinitialises the CRC and the beat count. A beat presented in the same cycle as `frameStart` counts as the first beat of the new frame.
- R9: Beats presented after the sixth beat and before the next `frameStart` are ignored. `accept` and `hashIndex` keep their values and `decisionValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Start of a frame; restarts CRC and beat count |
| beatValid | input | 1 | `beatData` carries an address beat |
| beatData | input | STEP_BITS | Address beat, earliest bit in bit 0 |
| stationHi | input | 32 | Station address bytes 0 to 3, byte 0 most significant |
| stationTail | input | 16 | Station address bytes 4 and 5, byte 4 most significant |
| hashUpper | input | 32 | Hash table entries 32 to 63 |
| hashLower | input | 32 | Hash table entries 0 to 31 |
| decisionValid | output | 1 | One-cycle pulse when the decision is ready |
| accept | output | 1 | Frame accepted (valid from the decision until the next frame start) |
| hashIndex | output | 6 | Top six CRC bits |

## Verification
The assertions assume that the station address and hash table inputs stay static while a frame is being received. They also assume that every frame begins with a `frameStart` pulse, and that the pulse is not repeated inside the six beats. The bench changes the table and address inputs only between frames, always opens a frame with `frameStart`, and inserts idle gaps only between beats. It sends further beats only after the decision, to exercise the ignore rule.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int ADDR_BITS = 48;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic init;
    logic step;
  } daf_strobe_t;
endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
#(
  parameter int BEATS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frameStart,
  input  logic        beatValid,
  output daf_strobe_t strb,
  output logic        decisionValid
);
  localparam int CW = $clog2(BEATS + 1);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);
  localparam logic [CW-1:0] FULL = CW'(BEATS);

  logic [CW-1:0] beatCnt;
  logic [CW-1:0] baseCnt;

  always_comb begin
    baseCnt   = frameStart ? '0 : beatCnt;
    strb.init = frameStart;
    strb.step = beatValid && (baseCnt != FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatCnt       <= FULL;
      decisionValid <= 1'b0;
    end else begin
      if (strb.step) beatCnt <= baseCnt + 1'b1;
      else           beatCnt <= baseCnt;
      decisionValid <= strb.step && (baseCnt == LAST);
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beatCnt <= FULL);

  assert_decision_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    decisionValid |-> $past(strb.step));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    decisionValid |=> !decisionValid);
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
#(
  parameter int STEP_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  daf_strobe_t          strb,
  input  logic [STEP_BITS-1:0] beatData,
  input  logic [31:0]          stationHi,
  input  logic [15:0]          stationTail,
  input  logic [31:0]          hashUpper,
  input  logic [31:0]          hashLower,
  output logic                 accept,
  output logic [5:0]           hashIndex
);
  localparam int NBYTES = ADDR_BITS / 8;

  logic [31:0]          crcQ, crcBase, crcD;
  logic [ADDR_BITS-1:0] addrQ, addrBase, addrD;
  logic [ADDR_BITS-1:0] stationStream;
  logic [ADDR_BITS-1:0] stationNatural;

  function automatic logic [31:0] crcAdvance(input logic [31:0] c,
                                             input logic [STEP_BITS-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < STEP_BITS; i++)
      r = (d[i] ^ r[0]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  // Stream layout: bits of byte n sit at [8n+7:8n], byte 0 first on the wire.
  assign stationNatural = {stationHi, stationTail};
  for (genvar n = 0; n < NBYTES; n++) begin : g_station
    assign stationStream[8*n +: 8] = stationNatural[ADDR_BITS-1-8*n -: 8];
  end

  always_comb begin
    crcBase  = strb.init ? '1 : crcQ;
    addrBase = strb.init ? '0 : addrQ;
    crcD     = strb.step ? crcAdvance(crcBase, beatData) : crcBase;
    addrD    = strb.step ? {beatData, addrBase[ADDR_BITS-1:STEP_BITS]} : addrBase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcQ  <= '1;
      addrQ <= '0;
    end else begin
      crcQ  <= crcD;
      addrQ <= addrD;
    end
  end

  logic exactHit, bcastHit, hashHit;
  always_comb begin
    hashIndex = crcQ[31:26];
    exactHit  = (addrQ == stationStream);
    bcastHit  = &addrQ;
    hashHit   = hashIndex[5] ? hashUpper[hashIndex[4:0]] : hashLower[hashIndex[4:0]];
    accept    = exactHit | bcastHit | hashHit;
  end

  assert_init_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.init && !strb.step) |=> (hashIndex == 6'h3F));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.init && !strb.step) |=> ($stable(crcQ) && $stable(addrQ)));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int STEP_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frameStart,
  input  logic                 beatValid,
  input  logic [STEP_BITS-1:0] beatData,
  input  logic [31:0]          stationHi,
  input  logic [15:0]          stationTail,
  input  logic [31:0]          hashUpper,
  input  logic [31:0]          hashLower,
  output logic                 decisionValid,
  output logic                 accept,
  output logic [5:0]           hashIndex
);
  localparam int BEATS = ADDR_BITS / STEP_BITS;

  daf_strobe_t strb;

  daf_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .beatValid(beatValid),
    .strb(strb), .decisionValid(decisionValid)
  );

  daf_datapath #(.STEP_BITS(STEP_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .beatData(beatData),
    .stationHi(stationHi), .stationTail(stationTail),
    .hashUpper(hashUpper), .hashLower(hashLower),
    .accept(accept), .hashIndex(hashIndex)
  );
endmodule

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic frameStart = 0, beatValid = 0;
  logic [7:0] beatData = 0;
  logic [31:0] stationHi = 0, hashUpper = 0, hashLower = 0;
  logic [15:0] stationTail = 0;
  logic decisionValid, accept;
  logic [5:0] hashIndex;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .beatValid(beatValid),
    .beatData(beatData), .stationHi(stationHi), .stationTail(stationTail),
    .hashUpper(hashUpper), .hashLower(hashLower),
    .decisionValid(decisionValid), .accept(accept), .hashIndex(hashIndex)
  );

  function automatic logic [31:0] refCrc(input logic [47:0] mac);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] cur = mac[47-8*b -: 8];
      for (int i = 0; i < 8; i++)
        c = (cur[i] ^ c[0]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [5:0] refIdx(input logic [47:0] mac);
    logic [31:0] c = refCrc(mac);
    return c[31:26];
  endfunction

  function automatic logic refAccept(input logic [47:0] mac);
    logic [5:0] idx = refIdx(mac);
    logic hh = idx[5] ? hashUpper[idx[4:0]] : hashLower[idx[4:0]];
    return (mac == {stationHi, stationTail}) || (&mac) || hh;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic [47:0] mac, input bit overlap, input bit gaps,
                          input int extra, input string req);
    logic [5:0] ei = refIdx(mac);
    logic ea = refAccept(mac);
    @(negedge clk);
    if (!overlap) begin
      frameStart = 1; @(negedge clk); frameStart = 0;
    end
    for (int n = 0; n < 6; n++) begin
      frameStart = overlap && (n == 0);
      beatValid = 1;
      beatData = mac[47-8*n -: 8];
      @(negedge clk);
      frameStart = 0; beatValid = 0;
      if (n < 5) begin
        check({req, " R7 no early decision"}, decisionValid, 0);
        if (gaps && ($urandom % 2 == 1)) @(negedge clk);
      end
    end
    check({req, " R7 decision pulse"}, decisionValid, 1);
    check({req, " R2 hashIndex"}, hashIndex, ei);
    check({req, " accept"}, accept, ea);
    for (int k = 0; k < extra; k++) begin
      beatValid = 1; beatData = 8'($urandom); @(negedge clk);
      beatValid = 0;
      check({req, " R9 no decision on extra beat"}, decisionValid, 0);
    end
    if (extra > 0) begin
      check({req, " R9 hashIndex held"}, hashIndex, ei);
      check({req, " R9 accept held"}, accept, ea);
    end else begin
      @(negedge clk);
      check({req, " R7 pulse ends"}, decisionValid, 0);
    end
  endtask

  initial begin
    logic [47:0] mac;
    logic [5:0] idx;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 decisionValid reset", decisionValid, 0);
    check("R1 hashIndex reset", hashIndex, 6'h3F);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", hashIndex, 6'h3F);

    // Broadcast with empty tables and a different station
    stationHi = 32'h02112233; stationTail = 16'h4455;
    runFrame(48'hFFFFFFFFFFFF, 0, 0, 0, "R4 broadcast");
    check("R4 broadcast accept", accept, 1);

    // Exact match
    runFrame(48'h021122334455, 0, 1, 0, "R3 exact");
    check("R3 exact accept", accept, 1);

    // Differs in last byte only: reject unless hash hits
    mac = 48'h021122334454; idx = refIdx(mac);
    hashUpper = 0; hashLower = 0;
    runFrame(mac, 0, 0, 0, "R6 near miss");
    check("R6 reject", accept, 0);

    // Hash bit set in the selected word
    mac = 48'h0A1B2C3D4E5F; idx = refIdx(mac);
    if (idx[5]) hashUpper = 32'h1 << idx[4:0]; else hashLower = 32'h1 << idx[4:0];
    runFrame(mac, 1, 0, 0, "R5 hash hit overlap R8");
    check("R5 hash accept", accept, 1);
    // Same bit only in the other word
    if (idx[5]) begin hashLower = hashUpper; hashUpper = 0; end
    else begin hashUpper = hashLower; hashLower = 0; end
    runFrame(mac, 0, 1, 0, "R5 other word");
    check("R5 other word reject", accept, 0);

    // Extra beats ignored
    hashUpper = 0; hashLower = 0;
    runFrame(48'h021122334455, 0, 0, 3, "R9 extra after exact");

    // Aborted frame then restart reinitialises
    @(negedge clk); frameStart = 1; @(negedge clk); frameStart = 0;
    beatValid = 1; beatData = 8'h5A; @(negedge clk); beatValid = 0;
    runFrame(48'h00C0FFEE0001, 0, 0, 0, "R8 restart after partial");

    // Random frames
    for (int t = 0; t < 60; t++) begin
      int sel = $urandom % 4;
      mac = {16'($urandom), 32'($urandom)};
      hashUpper = $urandom & $urandom; hashLower = $urandom & $urandom;
      stationHi = $urandom; stationTail = 16'($urandom);
      if (sel == 0) {stationHi, stationTail} = mac;
      if (sel == 1) mac = 48'hFFFFFFFFFFFF;
      runFrame(mac, ($urandom % 2) == 1, ($urandom % 2) == 1, $urandom % 3,
               "R2 R3 R4 R5 R6 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule